// File: doc/BRIEF.md
# Serial Synthesizer Control Register

This block is the three-wire programming front end of a frequency synthesizer, reduced to one control register. A serial data line is shifted into a 24-bit word on the rising edge of the serial clock, most significant bit first, while the latch-enable line is low. A rising latch-enable, seen at a serial clock edge, transfers the word. The two lowest bits of the word are an address, and only address `00` reaches the one register built here.

The register holds two fields. The first is a fractional-modulus select bit, which chooses a modulus of 15 or 16. The second is a 3-bit output-select code. That code steers one of four internal signals to a single status pin: analog lock, digital lock, the N-divider output or the R-divider output. Four of the eight codes are disallowed. Loading one of them drives the pin low and raises a sticky error flag, which only reset clears. All other bits of the word are don't-care.

Top module: `synth_ctl_port`

## Requirements
- R1: Serial bits are taken MSB first. After 24 shifts, the first bit shifted in sits at word bit 23 and the last one at bit 0.
- R2: On a clock edge where `ser_le` is high and was low at the previous edge, a word whose bits 1:0 are `00` is loaded. Bit 20 goes to the modulus select and bits 19:17 go to the output-select code. The new values show from that edge on.
- R3: `frac_mod16_o` is 1 when the loaded bit 20 is 1, meaning modulus 16. It is 0 when bit 20 is 0, meaning modulus 15.
- R4: The status pin `stat_o` routes according to the output-select code: `000` gives `lock_ana_i`, `010` gives `lock_dig_i`, `110` gives `ndiv_i` and `111` gives `rdiv_i`.
- R5: Under the codes `001`, `011`, `100` and `101`, `stat_o` is 0 whatever the four sources do.
- R6: Loading one of the reserved codes sets `osel_err_o`. It stays set through later loads until reset.
- R7: A latch of a word whose bits 1:0 are `01`, `10` or `11` leaves the modulus select, the routing and the error flag unchanged.
- R8: Word bits 21 and 16 down to 2 have no effect on any output.
- R9: Clock edges while `ser_le` stays high neither shift the word nor load it again.
- R10: After reset the modulus select is 0 (modulus 15), the code is `000` (analog lock routed) and `osel_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; shifting and latching occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch enable; a low-to-high change transfers the word |
| lock_ana_i | input | 1 | Analog lock-detect source |
| lock_dig_i | input | 1 | Digital lock-detect source |
| ndiv_i | input | 1 | N-divider output source |
| rdiv_i | input | 1 | R-divider output source |
| frac_mod16_o | output | 1 | 1 selects modulus 16, 0 selects modulus 15 |
| stat_o | output | 1 | Multiplexed status pin |
| osel_err_o | output | 1 | Sticky flag: a reserved output code was loaded |

## Verification
The bench sweeps all eight output codes against both modulus values and all four addresses. Every word carries random don't-care bits, which separates the decoded fields from the ignored ones. It also shows that foreign addresses change nothing. After each load, the bench drives each source alone and then all sources high. This catches a swapped mux leg and a reserved code that leaks a source to the pin. In a second pass, the latch is raised in the middle of a word and held for several edges while the data line toggles. The bench then finishes the word. This shows whether held-high edges shift or reload the word, and whether the bit order is right.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;

   typedef enum logic [2:0] {
      OSEL_ALOCK = 3'b000,
      OSEL_RSV1  = 3'b001,
      OSEL_DLOCK = 3'b010,
      OSEL_RSV3  = 3'b011,
      OSEL_RSV4  = 3'b100,
      OSEL_RSV5  = 3'b101,
      OSEL_NDIV  = 3'b110,
      OSEL_RDIV  = 3'b111
   } osel_e;

   typedef struct packed {
      logic  mod16;
      osel_e osel;
   } f1_t;

   localparam f1_t F1_RESET = '{mod16: 1'b0, osel: OSEL_ALOCK};

   function automatic logic osel_reserved(input osel_e c);
      case (c)
         OSEL_ALOCK, OSEL_DLOCK, OSEL_NDIV, OSEL_RDIV: osel_reserved = 1'b0;
         default:                                     osel_reserved = 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/ser_shifter.sv
module ser_shifter #(
   parameter int WORD_W    = 24,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sdata,
   input  logic              le,
   output logic [WORD_W-1:0] word,
   output logic              latch_pulse
);

   logic le_q;
   logic [WORD_W-1:0] word_nx;

   initial begin
      if (WORD_W < 4) $fatal(1, "ser_shifter: WORD_W too small");
   end

   generate
      if (MSB_FIRST) begin : g_msb
         assign word_nx = {word[WORD_W-2:0], sdata};
      end else begin : g_lsb
         assign word_nx = {sdata, word[WORD_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word <= '0;
         le_q <= 1'b0;
      end else begin
         le_q <= le;
         if (!le) word <= word_nx;
      end
   end

   assign latch_pulse = le & ~le_q;

   // R9: edges while latch enable is high do not move the word
   p_hold_while_le_r9: assert property (@(posedge clk) disable iff (!rst_n)
      le |=> $stable(word));

   // R1: with latch enable low the newest bit enters at the LSB
   p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!le && MSB_FIRST) |=> (word[0] == $past(sdata)));

endmodule

// File: rtl/f1_store.sv
module f1_store
   import synth_ctl_pkg::*;
#(
   parameter int WORD_W    = 24,
   parameter int ADDR_W    = 2,
   parameter int ADDR_CODE = 0,
   parameter int MOD_BIT   = 20,
   parameter int SEL_LSB   = 17,
   parameter int SEL_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              latch,
   input  logic [WORD_W-1:0] word,
   output f1_t               f1,
   output logic              err
);

   localparam int SEL_MSB = SEL_LSB + SEL_W - 1;

   initial begin
      if (SEL_W != 3)            $fatal(1, "f1_store: SEL_W must be 3");
      if (MOD_BIT >= WORD_W)     $fatal(1, "f1_store: MOD_BIT out of range");
      if (SEL_MSB >= WORD_W)     $fatal(1, "f1_store: select field out of range");
      if (SEL_LSB < ADDR_W)      $fatal(1, "f1_store: select overlaps address");
      if (ADDR_CODE >= (1 << ADDR_W)) $fatal(1, "f1_store: ADDR_CODE too wide");
   end

   logic  hit;
   f1_t   f1_nx;

   assign hit = latch && (word[ADDR_W-1:0] == ADDR_W'(ADDR_CODE));

   always_comb begin
      f1_nx.mod16 = word[MOD_BIT];
      f1_nx.osel  = osel_e'(word[SEL_MSB:SEL_LSB]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f1  <= F1_RESET;
         err <= 1'b0;
      end else if (hit) begin
         f1  <= f1_nx;
         err <= err | osel_reserved(f1_nx.osel);
      end
   end

   // R7: a latch to a foreign address keeps the register and the flag
   p_foreign_addr_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (latch && word[ADDR_W-1:0] != ADDR_W'(ADDR_CODE)) |=> ($stable(f1) && $stable(err)));

   // R2: a matching latch lands the word fields in the register
   p_load_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (latch && word[ADDR_W-1:0] == ADDR_W'(ADDR_CODE)) |=>
         (f1.mod16 == $past(word[MOD_BIT]) && f1.osel == $past(word[SEL_MSB:SEL_LSB])));

   // R6: the error flag never clears outside reset
   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R6: the flag rises only together with a reserved code
   p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> osel_reserved(f1.osel));

endmodule

// File: rtl/stat_mux.sv
module stat_mux
   import synth_ctl_pkg::*;
#(
   parameter bit RSV_LEVEL = 1'b0
) (
   input  osel_e osel,
   input  logic  lock_ana,
   input  logic  lock_dig,
   input  logic  ndiv,
   input  logic  rdiv,
   output logic  stat
);

   logic routed;

   always_comb begin
      case (osel)
         OSEL_ALOCK: routed = lock_ana;
         OSEL_DLOCK: routed = lock_dig;
         OSEL_NDIV:  routed = ndiv;
         OSEL_RDIV:  routed = rdiv;
         default:    routed = 1'b0;
      endcase
   end

   generate
      if (RSV_LEVEL) begin : g_rsv_high
         assign stat = osel_reserved(osel) ? 1'b1 : routed;
      end else begin : g_rsv_low
         assign stat = routed;
      end
   endgenerate

endmodule

// File: rtl/synth_ctl_port.sv
module synth_ctl_port
   import synth_ctl_pkg::*;
#(
   parameter int WORD_W    = 24,
   parameter int ADDR_W    = 2,
   parameter int F1_ADDR   = 0,
   parameter int MOD_BIT   = 20,
   parameter int SEL_LSB   = 17,
   parameter int SEL_W     = 3,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ser_data,
   input  logic ser_le,
   input  logic lock_ana_i,
   input  logic lock_dig_i,
   input  logic ndiv_i,
   input  logic rdiv_i,
   output logic frac_mod16_o,
   output logic stat_o,
   output logic osel_err_o
);

   logic [WORD_W-1:0] word;
   logic              latch_pulse;
   f1_t               f1;

   ser_shifter #(
      .WORD_W   (WORD_W),
      .MSB_FIRST(MSB_FIRST)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .sdata      (ser_data),
      .le         (ser_le),
      .word       (word),
      .latch_pulse(latch_pulse)
   );

   f1_store #(
      .WORD_W   (WORD_W),
      .ADDR_W   (ADDR_W),
      .ADDR_CODE(F1_ADDR),
      .MOD_BIT  (MOD_BIT),
      .SEL_LSB  (SEL_LSB),
      .SEL_W    (SEL_W)
   ) u_f1 (
      .clk  (clk),
      .rst_n(rst_n),
      .latch(latch_pulse),
      .word (word),
      .f1   (f1),
      .err  (osel_err_o)
   );

   stat_mux #(
      .RSV_LEVEL(1'b0)
   ) u_mux (
      .osel    (f1.osel),
      .lock_ana(lock_ana_i),
      .lock_dig(lock_dig_i),
      .ndiv    (ndiv_i),
      .rdiv    (rdiv_i),
      .stat    (stat_o)
   );

   assign frac_mod16_o = f1.mod16;

   // R5: reserved codes hold the pin low
   p_rsv_pin_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      osel_reserved(f1.osel) |-> !stat_o);

   // R6: a reserved code in the register implies the flag
   p_rsv_flagged_r6: assert property (@(posedge clk) disable iff (!rst_n)
      osel_reserved(f1.osel) |-> osel_err_o);

   // R4: digital-lock code follows its source
   p_route_dlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (f1.osel == OSEL_DLOCK) |-> (stat_o == lock_dig_i));

endmodule

// File: tb/synth_ctl_port_bench.sv
`timescale 1ns/100ps
module synth_ctl_port_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_data = 1'b0, ser_le = 1'b0;
   logic lock_ana_i = 1'b0, lock_dig_i = 1'b0, ndiv_i = 1'b0, rdiv_i = 1'b0;
   logic frac_mod16_o, stat_o, osel_err_o;

   int checks = 0;
   int fails  = 0;

   // bench model, built from the requirements
   logic [23:0] m_word = '0;
   logic        m_mod  = 1'b0;
   logic [2:0]  m_code = 3'b000;
   logic        m_err  = 1'b0;

   always #2 clk = ~clk;

   synth_ctl_port u_synth_ctl_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .ser_data    (ser_data),
      .ser_le      (ser_le),
      .lock_ana_i  (lock_ana_i),
      .lock_dig_i  (lock_dig_i),
      .ndiv_i      (ndiv_i),
      .rdiv_i      (rdiv_i),
      .frac_mod16_o(frac_mod16_o),
      .stat_o      (stat_o),
      .osel_err_o  (osel_err_o)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic exp_stat(input logic [2:0] c, input logic [3:0] s);
      case (c)
         3'b000:  exp_stat = s[0];
         3'b010:  exp_stat = s[1];
         3'b110:  exp_stat = s[2];
         3'b111:  exp_stat = s[3];
         default: exp_stat = 1'b0;
      endcase
   endfunction

   function automatic logic is_rsv(input logic [2:0] c);
      is_rsv = (c == 3'b001) || (c == 3'b011) || (c == 3'b100) || (c == 3'b101);
   endfunction

   task automatic shift_bit(input logic b);
      @(negedge clk);
      ser_le   = 1'b0;
      ser_data = b;
      m_word   = {m_word[22:0], b};
      @(posedge clk);
   endtask

   task automatic shift_word(input logic [23:0] w, input int nbits);
      for (int i = 23; i > 23 - nbits; i--) shift_bit(w[i]);
   endtask

   // raise the latch and hold it for extra edges with a toggling data line
   task automatic latch_hold(input int extra);
      @(negedge clk);
      ser_le = 1'b1;
      if (m_word[1:0] == 2'b00) begin
         m_mod  = m_word[20];
         m_code = m_word[19:17];
         m_err  = m_err | is_rsv(m_word[19:17]);
      end
      @(posedge clk);
      for (int k = 0; k < extra; k++) begin
         @(negedge clk);
         ser_data = ~ser_data;
         @(posedge clk);
      end
   endtask

   task automatic check_state(input string tag);
      logic [3:0] pats [5];
      pats[0] = 4'b0001; pats[1] = 4'b0010; pats[2] = 4'b0100;
      pats[3] = 4'b1000; pats[4] = 4'b1111;
      @(negedge clk);
      chk({tag, " R3 modulus"}, frac_mod16_o, m_mod);
      chk({tag, " R6 error flag"}, osel_err_o, m_err);
      for (int p = 0; p < 5; p++) begin
         @(negedge clk);
         {rdiv_i, ndiv_i, lock_dig_i, lock_ana_i} = pats[p];
         #1;
         chk(is_rsv(m_code) ? {tag, " R5 reserved low"} : {tag, " R4 routing"},
             stat_o, exp_stat(m_code, pats[p]));
      end
      @(negedge clk);
      {rdiv_i, ndiv_i, lock_dig_i, lock_ana_i} = 4'b0000;
   endtask

   initial begin
      #(100000 * 4);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [23:0] w;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_state("R10 reset");

      // R1 R2 R7 R8: sweep codes, modulus bit and address with random ignored bits
      for (int c = 0; c < 8; c++) begin
         for (int m = 0; m < 2; m++) begin
            for (int a = 3; a >= 0; a--) begin
               w        = 24'($urandom);
               w[1:0]   = 2'(a);
               w[20]    = m[0];
               w[19:17] = 3'(c);
               shift_word(w, 24);
               latch_hold(0);
               check_state(a == 0 ? "R2 load" : "R7 foreign addr");
            end
         end
      end

      // R10: reset returns everything to its default
      @(negedge clk);
      rst_n = 1'b0;
      m_word = '0; m_mod = 1'b0; m_code = 3'b000; m_err = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check_state("R10 second reset");

      // R9: latch mid-word, hold high across toggling data, then finish the word
      w        = 24'h2EC5A0;
      w[1:0]   = 2'b00;
      w[20]    = 1'b1;
      w[19:17] = 3'b110;
      shift_word(w, 20);
      latch_hold(6);
      check_state("R9 partial latch");
      for (int i = 3; i >= 0; i--) shift_bit(w[i]);
      latch_hold(5);
      check_state("R9 R1 finished word");
      chk("R1 MSB-first modulus", frac_mod16_o, 1'b1);

      // R8: only ignored bits differ from the loaded word
      w = w ^ 24'h21FFFC;
      shift_word(w, 24);
      latch_hold(1);
      check_state("R8 ignored bits");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule